// File: doc/BRIEF.md
# Multi-Core Global Timer with Comparators

This block is a single free-running 64-bit time base that several processor cores (one to four, set by a parameter) share. The counter has one shared enable and an 8-bit prescaler. The prescaler stretches each counter step over several input clock cycles. Each core owns a private 64-bit comparator, a 32-bit auto-increment step and three banked enable bits: compare, interrupt and auto-increment. It also has a sticky event flag and its own interrupt line.

Software reaches the block through a plain 32-bit register bus with a write strobe, a byte address and a combinational read path. The address space is cut into 32-byte windows. Window 0 is the "current core" window: its accesses go to the core named by the `coreId` input. Window 1 + i is the private window of core i. Every window holds the same seven registers. The counter registers are the same storage in every window. The comparator, increment, status and banked control bits belong to the window's core.

A core raises its interrupt when its counter-versus-comparator event has been flagged and its interrupt enable is set. With auto-increment, the comparator steps forward by the programmed amount on each event, so the block can produce periodic ticks without software rewriting the comparator.

Top module: `mc_global_timer`

## Requirements
- R1: While the shared enable (control bit 0) is 1, the counter advances by exactly one on every (P + 1)-th clock edge, where P is control bits 15:8. The first step comes P + 1 edges after the enabling write. While the enable is 0, the counter holds its value.
- R2: A write to offset 0x00 (low 32 bits) or 0x04 (high 32 bits) of the counter replaces only that half, and only while the shared enable is 0. While the enable is 1, such writes are discarded.
- R3: Control bit 0 (timer enable) and bits 15:8 (prescaler) are shared by all cores. Bit 1 (compare enable), bit 2 (interrupt enable) and bit 3 (auto-increment enable) are banked per core. A control read at offset 0x08 returns the shared bits ORed with the addressed core's banked bits.
- R4: Each core's comparator (offset 0x10 low, 0x14 high) and auto-increment step (offset 0x18) are private. A write to one core leaves the other cores' values unchanged.
- R5: When the shared enable and a core's compare enable are both 1 and the counter is greater than or equal to that core's comparator, the core's status bit (offset 0x0C, bit 0) reads 1 after the next clock edge.
- R6: The status bit is sticky. Only a write with bit 0 = 1 to offset 0x0C clears it, and a write with bit 0 = 0 leaves it unchanged. When an event and a clearing write fall on the same edge, the event wins.
- R7: On an event, if the core's auto-increment enable is 1 and its step is nonzero, the comparator is increased by the step on the same edge that sets the status bit.
- R8: Interrupt output `irq[i]` is 1 exactly when core i's status bit and interrupt enable are both 1.
- R9: Address bits 7:5 select the window: 0 is the current-core window steered by `coreId`, and 1 + i is core i. Bits 4:2 select the register. Reads of offset 0x1C or of a window above the core count return 0, and writes to them change nothing.
- R10: Reset clears the counter, all control bits, every status bit, every comparator and every step to zero, and drives all interrupts low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreId | input | CID_W | Core issuing the access, used by the current-core window |
| busWrite | input | 1 | Write strobe, sampled on the rising edge |
| busAddr | input | ADDR_W | Byte address: window in bits 7:5, register in bits 4:2 |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| irq | output | NUM_CORES | Per-core interrupt lines |

## Verification
Reads are combinational, so read data is due in the same cycle that the address is applied. The bench samples it a short delay after driving the address, between clock edges. Register writes take effect at the edge that samples them. Counter values are due a whole number of prescaled periods after the enabling edge, and status, comparator steps and interrupts appear one edge after the counter reaches the comparator. The bench counts every edge from the enabling write and samples on the falling edge exactly at the counts where each value is first due and where it must not yet have changed.

// File: rtl/gt_pkg.sv
package gt_pkg;

  // Register selector decoded from address bits 4:2
  typedef enum logic [2:0] {
    REG_CNT_LO = 3'd0,
    REG_CNT_HI = 3'd1,
    REG_CTRL   = 3'd2,
    REG_STS    = 3'd3,
    REG_CMP_LO = 3'd4,
    REG_CMP_HI = 3'd5,
    REG_INC    = 3'd6,
    REG_NONE   = 3'd7
  } regIdx_e;

  // Write strobes from the decoder to the datapath, already qualified
  typedef struct packed {
    logic wrCntLo;
    logic wrCntHi;
    logic wrCtrl;
    logic wrSts;
    logic wrCmpLo;
    logic wrCmpHi;
    logic wrInc;
  } wrStrobe_t;

  // Control word bit positions
  localparam int BIT_TIMER_EN = 0;
  localparam int BIT_CMP_EN   = 1;
  localparam int BIT_IRQ_EN   = 2;
  localparam int BIT_AUTO_EN  = 3;
  localparam int PRESC_LSB    = 8;

  localparam int WIN_SHIFT    = 5;   // 32-byte windows

endpackage

// File: rtl/gt_ctrl.sv
module gt_ctrl
  import gt_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 8,
  parameter int CID_W     = 1
) (
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CID_W-1:0]  coreId,
  output wrStrobe_t         wrStb,
  output logic [CID_W-1:0]  coreIdx,
  output regIdx_e           regSel
);

  localparam int WIN_W = ADDR_W - WIN_SHIFT;

  logic [WIN_W-1:0] win;
  logic [2:0]       offset;
  logic             hit;
  logic [1:0]       unusedAddrBits;

  assign win            = busAddr[ADDR_W-1:WIN_SHIFT];
  assign offset         = busAddr[4:2];
  assign unusedAddrBits = busAddr[1:0];

  // Window steering: 0 follows coreId, 1+i is core i
  always_comb begin
    hit     = 1'b0;
    coreIdx = '0;
    if (win == '0) begin
      if (int'(coreId) < NUM_CORES) begin
        hit     = 1'b1;
        coreIdx = coreId;
      end
    end else if (int'(win) <= NUM_CORES) begin
      hit     = 1'b1;
      coreIdx = CID_W'(win - WIN_W'(1));
    end
  end

  assign regSel = hit ? regIdx_e'(offset) : REG_NONE;

  always_comb begin
    wrStb = '0;
    if (busWrite) begin
      unique case (regSel)
        REG_CNT_LO: wrStb.wrCntLo = 1'b1;
        REG_CNT_HI: wrStb.wrCntHi = 1'b1;
        REG_CTRL:   wrStb.wrCtrl  = 1'b1;
        REG_STS:    wrStb.wrSts   = 1'b1;
        REG_CMP_LO: wrStb.wrCmpLo = 1'b1;
        REG_CMP_HI: wrStb.wrCmpHi = 1'b1;
        REG_INC:    wrStb.wrInc   = 1'b1;
        default:    wrStb = '0;
      endcase
    end
  end

endmodule

// File: rtl/gt_bank.sv
module gt_bank
  import gt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  wrStrobe_t         wrStb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              timerEn,
  output logic [CNT_W-1:0]  cmp,
  output logic [DATA_W-1:0] inc,
  output logic              cmpEn,
  output logic              irqEn,
  output logic              autoEn,
  output logic              status,
  output logic              irq
);

  logic event_;
  logic doStep;

  assign event_ = timerEn && cmpEn && (count >= cmp);
  assign doStep = event_ && autoEn && (inc != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmp    <= '0;
      inc    <= '0;
      cmpEn  <= 1'b0;
      irqEn  <= 1'b0;
      autoEn <= 1'b0;
      status <= 1'b0;
    end else begin
      if (sel && wrStb.wrCtrl) begin
        cmpEn  <= wdata[BIT_CMP_EN];
        irqEn  <= wdata[BIT_IRQ_EN];
        autoEn <= wdata[BIT_AUTO_EN];
      end
      if (event_) begin
        status <= 1'b1;
      end else if (sel && wrStb.wrSts && wdata[0]) begin
        status <= 1'b0;
      end
      if (sel && wrStb.wrCmpLo) begin
        cmp[DATA_W-1:0] <= wdata;
      end else if (sel && wrStb.wrCmpHi) begin
        cmp[CNT_W-1:DATA_W] <= wdata;
      end else if (doStep) begin
        cmp <= cmp + {{(CNT_W-DATA_W){1'b0}}, inc};
      end
      if (sel && wrStb.wrInc) begin
        inc <= wdata;
      end
    end
  end

  assign irq = status && irqEn;

endmodule

// File: rtl/gt_datapath.sv
module gt_datapath
  import gt_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int DATA_W    = 32,
  parameter int PRESC_W   = 8,
  parameter int CID_W     = 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  wrStrobe_t                       wrStb,
  input  logic [CID_W-1:0]                coreIdx,
  input  regIdx_e                         regSel,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic [NUM_CORES-1:0]            irq,
  output logic                            timerEn,
  output logic [2*DATA_W-1:0]             count,
  output logic [NUM_CORES-1:0][2*DATA_W-1:0] cmpVec,
  output logic [NUM_CORES-1:0]            cmpEnVec,
  output logic [NUM_CORES-1:0]            statusVec
);

  localparam int CNT_W = 2 * DATA_W;

  logic [PRESC_W-1:0]               presc;
  logic [PRESC_W-1:0]               preCnt;
  logic [NUM_CORES-1:0][DATA_W-1:0] incVec;
  logic [NUM_CORES-1:0]             irqEnVec;
  logic [NUM_CORES-1:0]             autoEnVec;
  logic [DATA_W-1:0]                ctrlWord;

  // Shared control and prescaled counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerEn <= 1'b0;
      presc   <= '0;
      preCnt  <= '0;
      count   <= '0;
    end else begin
      if (wrStb.wrCtrl) begin
        timerEn <= wdata[BIT_TIMER_EN];
        presc   <= wdata[PRESC_LSB +: PRESC_W];
      end
      if (timerEn) begin
        if (preCnt == presc) begin
          preCnt <= '0;
          count  <= count + CNT_W'(1);
        end else begin
          preCnt <= preCnt + PRESC_W'(1);
        end
      end else begin
        preCnt <= '0;
        if (wrStb.wrCntLo) count[DATA_W-1:0]     <= wdata;
        if (wrStb.wrCntHi) count[CNT_W-1:DATA_W] <= wdata;
      end
    end
  end

  // Per-core banks
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_bank
    gt_bank #(
      .DATA_W(DATA_W),
      .CNT_W (CNT_W)
    ) u_bank (
      .clk    (clk),
      .rstN   (rstN),
      .sel    (coreIdx == CID_W'(i)),
      .wrStb  (wrStb),
      .wdata  (wdata),
      .count  (count),
      .timerEn(timerEn),
      .cmp    (cmpVec[i]),
      .inc    (incVec[i]),
      .cmpEn  (cmpEnVec[i]),
      .irqEn  (irqEnVec[i]),
      .autoEn (autoEnVec[i]),
      .status (statusVec[i]),
      .irq    (irq[i])
    );
  end

  // Read path
  always_comb begin
    ctrlWord                        = '0;
    ctrlWord[PRESC_LSB +: PRESC_W]  = presc;
    ctrlWord[BIT_TIMER_EN]          = timerEn;
    ctrlWord[BIT_CMP_EN]            = cmpEnVec[coreIdx];
    ctrlWord[BIT_IRQ_EN]            = irqEnVec[coreIdx];
    ctrlWord[BIT_AUTO_EN]           = autoEnVec[coreIdx];
  end

  always_comb begin
    unique case (regSel)
      REG_CNT_LO: rdata = count[DATA_W-1:0];
      REG_CNT_HI: rdata = count[CNT_W-1:DATA_W];
      REG_CTRL:   rdata = ctrlWord;
      REG_STS:    rdata = DATA_W'(statusVec[coreIdx]);
      REG_CMP_LO: rdata = cmpVec[coreIdx][DATA_W-1:0];
      REG_CMP_HI: rdata = cmpVec[coreIdx][CNT_W-1:DATA_W];
      REG_INC:    rdata = incVec[coreIdx];
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/mc_global_timer.sv
module mc_global_timer
  import gt_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int PRESC_W   = 8,
  parameter int CID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CID_W-1:0]     coreId,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic [NUM_CORES-1:0] irq
);

  localparam int CNT_W = 2 * DATA_W;

  wrStrobe_t                       wrStb;
  logic [CID_W-1:0]                coreIdx;
  regIdx_e                         regSel;
  logic                            timerEn;
  logic [CNT_W-1:0]                cntVal;
  logic [NUM_CORES-1:0][CNT_W-1:0] cmpVec;
  logic [NUM_CORES-1:0]            cmpEnVec;
  logic [NUM_CORES-1:0]            statusVec;

  gt_ctrl #(
    .NUM_CORES(NUM_CORES),
    .ADDR_W   (ADDR_W),
    .CID_W    (CID_W)
  ) u_ctrl (
    .busWrite(busWrite),
    .busAddr (busAddr),
    .coreId  (coreId),
    .wrStb   (wrStb),
    .coreIdx (coreIdx),
    .regSel  (regSel)
  );

  gt_datapath #(
    .NUM_CORES(NUM_CORES),
    .DATA_W   (DATA_W),
    .PRESC_W  (PRESC_W),
    .CID_W    (CID_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .coreIdx  (coreIdx),
    .regSel   (regSel),
    .wdata    (busWdata),
    .rdata    (busRdata),
    .irq      (irq),
    .timerEn  (timerEn),
    .count    (cntVal),
    .cmpVec   (cmpVec),
    .cmpEnVec (cmpEnVec),
    .statusVec(statusVec)
  );

endmodule

// File: rtl/gt_checker.sv
module gt_checker
  import gt_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int CNT_W     = 64,
  parameter int CID_W     = 1
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            timerEn,
  input logic [CNT_W-1:0]                count,
  input logic [NUM_CORES-1:0][CNT_W-1:0] cmpVec,
  input logic [NUM_CORES-1:0]            cmpEnVec,
  input logic [NUM_CORES-1:0]            statusVec,
  input logic [NUM_CORES-1:0]            irq,
  input wrStrobe_t                       wrStb,
  input logic [CID_W-1:0]                coreIdx,
  input logic                            wdataBit0
);

  // R1: the counter never moves by more than one per edge while running
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    timerEn |=> (count == $past(count)) || (count == $past(count) + CNT_W'(1)));

  // R1, R2: with the timer stopped and no counter write, the value holds
  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!timerEn && !wrStb.wrCntLo && !wrStb.wrCntHi) |=> $stable(count));

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    // R5: a qualifying compare sets the flag on the next edge
    p_event_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
      (timerEn && cmpEnVec[i] && (count >= cmpVec[i])) |=> statusVec[i]);

    // R6: the flag only drops through a write-one-to-clear to this core
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
      (statusVec[i] && !(wrStb.wrSts && (coreIdx == CID_W'(i)) && wdataBit0))
        |=> statusVec[i]);

    // R8: no interrupt without a flagged event
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
      !statusVec[i] |-> !irq[i]);
  end

endmodule

bind mc_global_timer gt_checker #(
  .NUM_CORES(NUM_CORES),
  .CNT_W    (2 * DATA_W),
  .CID_W    (CID_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .timerEn  (timerEn),
  .count    (cntVal),
  .cmpVec   (cmpVec),
  .cmpEnVec (cmpEnVec),
  .statusVec(statusVec),
  .irq      (irq),
  .wrStb    (wrStb),
  .coreIdx  (coreIdx),
  .wdataBit0(busWdata[0])
);

// File: tb/sim_mc_global_timer.sv
module sim_mc_global_timer;

  localparam int NC = 2;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int CW = 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] coreId = '0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [NC-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  mc_global_timer #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .coreId(coreId), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  // {req[3:0], write, addr[7:0], wdata[31:0], expected[31:0]}; coreId = 1
  localparam int NV = 22;
  localparam logic [76:0] VEC [NV] = '{
    {4'd2, 1'b1, 8'h20, 32'h1111_1111, 32'h0},           // R2 counter low
    {4'd2, 1'b1, 8'h24, 32'h2222_2222, 32'h0},           // R2 counter high
    {4'd2, 1'b0, 8'h20, 32'h0, 32'h1111_1111},
    {4'd9, 1'b0, 8'h44, 32'h0, 32'h2222_2222},           // R9 shared counter, core 1 window
    {4'd9, 1'b0, 8'h04, 32'h0, 32'h2222_2222},           // R9 current window
    {4'd4, 1'b1, 8'h30, 32'hAAAA_0000, 32'h0},           // R4 core 0 comparator
    {4'd4, 1'b0, 8'h50, 32'h0, 32'h0},                   // R4 core 1 untouched
    {4'd4, 1'b0, 8'h30, 32'h0, 32'hAAAA_0000},
    {4'd9, 1'b0, 8'h10, 32'h0, 32'h0},                   // R9 current = core 1
    {4'd3, 1'b1, 8'h48, 32'h0000_0304, 32'h0},           // R3 presc 3 + core 1 irq enable
    {4'd3, 1'b0, 8'h28, 32'h0, 32'h0000_0300},           // R3 core 0 sees shared only
    {4'd3, 1'b0, 8'h48, 32'h0, 32'h0000_0304},
    {4'd3, 1'b0, 8'h08, 32'h0, 32'h0000_0304},
    {4'd4, 1'b1, 8'h18, 32'h0000_0005, 32'h0},           // R4 step via current window
    {4'd4, 1'b0, 8'h58, 32'h0, 32'h0000_0005},
    {4'd4, 1'b0, 8'h38, 32'h0, 32'h0},
    {4'd9, 1'b0, 8'h3C, 32'h0, 32'h0},                   // R9 undefined offset
    {4'd9, 1'b1, 8'hA0, 32'h0000_1234, 32'h0},           // R9 write to absent window
    {4'd9, 1'b0, 8'h20, 32'h0, 32'h1111_1111},
    {4'd9, 1'b0, 8'hA4, 32'h0, 32'h0},                   // R9 read of absent window
    {4'd4, 1'b1, 8'h34, 32'h1234_5678, 32'h0},           // R4 comparator high
    {4'd4, 1'b0, 8'h34, 32'h0, 32'h1234_5678}
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    busAddr  = a;
    busWdata = d;
    busWrite = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    busWrite = 1'b0;
    busAddr  = a;
    #1;
    check(tag, busRdata, exp);
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd("R10 counter low", 8'h20, 32'h0);
    rd("R10 control", 8'h28, 32'h0);
    rd("R10 status", 8'h2C, 32'h0);
    check("R10 irq", 32'(irq), 32'h0);

    // Table walk
    coreId = 1'b1;
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][72]) begin
        wr(VEC[k][71:64], VEC[k][63:32]);
      end else begin
        rd($sformatf("R%0d table entry %0d", VEC[k][76:73], k), VEC[k][71:64], VEC[k][31:0]);
      end
    end

    // R1 prescaler 3: one step every 4 edges
    coreId = 1'b0;
    wr(8'h28, 32'h0000_0300);
    wr(8'h20, 32'h0);
    wr(8'h24, 32'h0);
    wr(8'h28, 32'h0000_0301);
    waitEdges(10);
    rd("R1 presc 10 edges", 8'h20, 32'd2);
    waitEdges(1);
    rd("R1 presc 11 edges", 8'h20, 32'd2);
    waitEdges(1);
    rd("R1 presc 12 edges", 8'h20, 32'd3);
    rd("R1 high word", 8'h24, 32'd0);
    wr(8'h28, 32'h0000_0300);
    rd("R1 stop", 8'h20, 32'd3);
    waitEdges(5);
    rd("R1 hold while stopped", 8'h20, 32'd3);

    // R2 write discarded while running
    wr(8'h20, 32'h0);
    wr(8'h28, 32'h0000_0001);
    wr(8'h20, 32'hFFFF_0000);
    rd("R2 write ignored when running", 8'h20, 32'd1);

    // R1 carry into upper half
    wr(8'h28, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'h0000_0001);
    wr(8'h28, 32'h0000_0001);
    waitEdges(1);
    rd("R1 carry low", 8'h20, 32'h0);
    rd("R1 carry high", 8'h24, 32'h2);

    // R5 compare at >= boundary, core 0
    wr(8'h28, 32'h0);
    wr(8'h20, 32'h0);
    wr(8'h24, 32'h0);
    wr(8'h30, 32'd5);
    wr(8'h34, 32'h0);
    wr(8'h28, 32'h0000_0007);
    waitEdges(5);
    rd("R5 no event before edge", 8'h2C, 32'h0);
    check("R8 irq low before event", 32'(irq), 32'h0);
    waitEdges(1);
    rd("R5 event flagged", 8'h2C, 32'h1);
    check("R8 irq on event", 32'(irq), 32'h1);

    // R8 / R6 gating and sticky clear
    wr(8'h28, 32'h0000_0002);
    check("R8 irq masked", 32'(irq), 32'h0);
    rd("R6 flag kept after disable", 8'h2C, 32'h1);
    wr(8'h2C, 32'h0);
    rd("R6 write zero no effect", 8'h2C, 32'h1);
    wr(8'h28, 32'h0000_0006);
    check("R8 irq unmasked", 32'(irq), 32'h1);
    wr(8'h2C, 32'h1);
    rd("R6 write one clears", 8'h2C, 32'h0);
    check("R8 irq after clear", 32'(irq), 32'h0);

    // R7 auto-increment on core 1 through current window
    coreId = 1'b1;
    wr(8'h08, 32'h0000_000A);
    wr(8'h20, 32'h0);
    wr(8'h24, 32'h0);
    wr(8'h50, 32'd3);
    wr(8'h54, 32'h0);
    wr(8'h58, 32'd4);
    wr(8'h08, 32'h0000_000B);
    waitEdges(4);
    rd("R7 comparator stepped", 8'h50, 32'd7);
    rd("R5 core 1 flagged", 8'h4C, 32'h1);
    check("R8 core 1 irq disabled", 32'(irq[1]), 32'h0);
    waitEdges(1);
    rd("R7 no repeat step", 8'h50, 32'd7);
    waitEdges(3);
    rd("R7 second step", 8'h50, 32'd11);

    // R9 current-window write steering
    coreId = 1'b0;
    wr(8'h18, 32'd9);
    rd("R9 steered write core 0", 8'h38, 32'd9);
    rd("R9 core 1 step untouched", 8'h58, 32'd4);

    // R10 reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    waitEdges(2);
    rstN = 1'b1;
    rd("R10 counter low cleared", 8'h20, 32'h0);
    rd("R10 counter high cleared", 8'h24, 32'h0);
    rd("R10 control cleared", 8'h48, 32'h0);
    rd("R10 comparator cleared", 8'h50, 32'h0);
    rd("R10 step cleared", 8'h58, 32'h0);
    rd("R10 status cleared", 8'h2C, 32'h0);
    check("R10 irq cleared", 32'(irq), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule